// File: doc/BRIEF.md
# Round-Robin Router Output Channel

This block is one output port of a five-port mesh router. Every input channel of the router that holds a packet for this port raises its request line. The output channel grants one of them under rotating priority and drives the crossbar select with the index of the winner. It then takes flits from the crossbar into its own FIFO for as long as the source input FIFO reports that it still holds data.

When the source reports empty, the copy ends, and the grant and select return to their idle values. The buffered packet then goes to the neighbouring router over a request/acknowledge handshake. A new grant is issued only after the output FIFO has drained.

A build option marks the instance as a horizontal (East or West) port. With XY routing such a port can never be targeted by the North or South inputs, so requests on those lines are discarded.

Top module: `rr_out_chan`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gnt_o` is all zero, `xbar_sel_o` is 0 and `dn_req_o` is low.
- R2: At most one grant bit is high at any time. A grant goes only to an input whose request was high in the cycle the grant was taken, and it stays unchanged for the whole copy.
- R3: While a grant is high, `xbar_sel_o` holds the index of the granted input (Local=0, East=1, West=2, North=3, South=4). With no grant it reads 0.
- R4: The priority search starts at the port that follows the last granted port, in the circular order 0,1,2,3,4,0. After reset it starts at Local (0). When all five ports request from reset, they are served in the order 0,1,2,3,4.
- R5: In each cycle with the grant high and `src_empty_i` low, `xbar_data_i` is stored. A cycle with `src_empty_i` high ends the copy, and on the next cycle the grant is zero and the select is 0. A copy that is empty from its first cycle sends nothing downstream.
- R6: After a copy, `dn_req_o` is high for as long as stored flits remain, and `dn_data_o` shows the oldest stored flit. Each cycle with `dn_ack_i` high moves one flit. Flits leave in arrival order, and `dn_req_o` is low on the cycle after the last flit is acknowledged.
- R7: While `dn_req_o` is high and `dn_ack_i` is low, on the next cycle `dn_req_o` is still high and `dn_data_o` is unchanged.
- R8: No grant is issued while `dn_req_o` is high or while any flit of the previous packet is still stored.
- R9: In the horizontal variant, requests on North (3) and South (4) are never granted, even when they are the only ones present. The priority search skips them.
- R10: The FIFO holds 16 flits of 8 bits, and a 16-flit packet is delivered complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NPORTS | Request from each input channel |
| gnt_o | output | NPORTS | One-hot grant to the winning input channel |
| xbar_sel_o | output | SEL_W | Crossbar select, index of the granted input |
| xbar_data_i | input | DATA_W | Flit from the crossbar |
| src_empty_i | input | 1 | Empty flag of the granted source FIFO |
| dn_req_o | output | 1 | Request to the neighbouring router |
| dn_ack_i | input | 1 | Acknowledge from the neighbouring router |
| dn_data_o | output | DATA_W | Flit to the neighbouring router |

## Verification
Three kinds of request pattern are used.
- All five ports asking at once from reset fixes the starting point and direction of the rotation.
- A lone empty packet separates the copy-end path from the send path.
- A single full-length packet probes FIFO capacity and pointer wrap.

Long random runs then mix packets of 0 to 16 flits with an acknowledge that is often withheld. These runs check each grant against a model of the rotating pointer, and they expose ordering, stalling and overlap faults that directed cases miss. The horizontal instance gets only vertical requests, then vertical requests mixed with East or Local. This separates a plain mask from a search that wrongly stalls on masked ports.

// File: rtl/rr_oc_pkg.sv
package rr_oc_pkg;

   localparam int PORT_LOCAL = 0;
   localparam int PORT_EAST  = 1;
   localparam int PORT_WEST  = 2;
   localparam int PORT_NORTH = 3;
   localparam int PORT_SOUTH = 4;

   typedef enum logic [1:0] {
      OC_IDLE = 2'd0,
      OC_COPY = 2'd1,
      OC_SEND = 2'd2
   } oc_state_t;

endpackage

// File: rtl/rr_oc_mask.sv
module rr_oc_mask
   import rr_oc_pkg::*;
#(
   parameter int NPORTS  = 5,
   parameter bit LATERAL = 1'b0
) (
   input  logic [NPORTS-1:0] req_i,
   output logic [NPORTS-1:0] req_o
);

   generate
      if (LATERAL) begin : g_lateral
         localparam logic [NPORTS-1:0] VERT_M =
            (NPORTS'(1) << PORT_NORTH) | (NPORTS'(1) << PORT_SOUTH);
         assign req_o = req_i & ~VERT_M;
      end else begin : g_all
         assign req_o = req_i;
      end
   endgenerate

endmodule

// File: rtl/rr_oc_pick.sv
module rr_oc_pick #(
   parameter int NPORTS = 5,
   parameter int IDX_W  = 3
) (
   input  logic [NPORTS-1:0] req_i,
   input  logic [IDX_W-1:0]  start_i,
   output logic              found_o,
   output logic [IDX_W-1:0]  idx_o
);

   always_comb begin
      logic [IDX_W-1:0] cand;
      found_o = 1'b0;
      idx_o   = '0;
      cand    = '0;
      for (int k = 0; k < NPORTS; k++) begin
         cand = IDX_W'((int'(start_i) + k) % NPORTS);
         if (!found_o && req_i[cand]) begin
            found_o = 1'b1;
            idx_o   = cand;
         end
      end
   end

endmodule

// File: rtl/rr_oc_fifo.sv
module rr_oc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o,
   output logic         full_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty_o = (count == '0);
   assign full_o  = (count == CW'(DEPTH));
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign dout_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rr_out_chan.sv
module rr_out_chan
   import rr_oc_pkg::*;
#(
   parameter int NPORTS  = 5,
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int SEL_W   = 3,
   parameter bit LATERAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] req_i,
   output logic [NPORTS-1:0] gnt_o,
   output logic [SEL_W-1:0]  xbar_sel_o,
   input  logic [DATA_W-1:0] xbar_data_i,
   input  logic              src_empty_i,
   output logic              dn_req_o,
   input  logic              dn_ack_i,
   output logic [DATA_W-1:0] dn_data_o
);

   localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NPORTS - 1);

   initial begin
      assert (NPORTS >= 2 && NPORTS <= (1 << SEL_W))
         else $error("rr_out_chan: NPORTS does not fit SEL_W");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("rr_out_chan: DEPTH must be a power of two");
      assert (!LATERAL || NPORTS > PORT_SOUTH)
         else $error("rr_out_chan: lateral variant needs vertical ports");
   end

   oc_state_t         state_q;
   logic [NPORTS-1:0] gnt_q;
   logic [SEL_W-1:0]  sel_q;
   logic [SEL_W-1:0]  start_q;
   logic [NPORTS-1:0] req_ok;
   logic              found;
   logic [SEL_W-1:0]  win_idx;
   logic              fifo_empty, fifo_full, push, pop;

   rr_oc_mask #(.NPORTS(NPORTS), .LATERAL(LATERAL)) i_mask (
      .req_i (req_i),
      .req_o (req_ok)
   );

   rr_oc_pick #(.NPORTS(NPORTS), .IDX_W(SEL_W)) i_pick (
      .req_i   (req_ok),
      .start_i (start_q),
      .found_o (found),
      .idx_o   (win_idx)
   );

   assign push = (state_q == OC_COPY) && !src_empty_i && !fifo_full;
   assign pop  = (state_q == OC_SEND) && dn_ack_i && !fifo_empty;

   rr_oc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   (xbar_data_i),
      .pop_i   (pop),
      .dout_o  (dn_data_o),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= OC_IDLE;
         gnt_q   <= '0;
         sel_q   <= '0;
         start_q <= '0;
      end else begin
         case (state_q)
            OC_IDLE: begin
               if (found && fifo_empty) begin
                  state_q <= OC_COPY;
                  gnt_q   <= NPORTS'(1) << win_idx;
                  sel_q   <= win_idx;
                  start_q <= (win_idx == LAST_IDX) ? '0 : win_idx + SEL_W'(1);
               end
            end
            OC_COPY: begin
               if (src_empty_i) begin
                  state_q <= OC_SEND;
                  gnt_q   <= '0;
                  sel_q   <= '0;
               end
            end
            OC_SEND: begin
               if (fifo_empty) state_q <= OC_IDLE;
            end
            default: state_q <= OC_IDLE;
         endcase
      end
   end

   assign gnt_o      = gnt_q;
   assign xbar_sel_o = sel_q;
   assign dn_req_o   = (state_q == OC_SEND) && !fifo_empty;

endmodule

// File: rtl/rr_out_chan_chk.sv
module rr_out_chan_chk
   import rr_oc_pkg::*;
#(
   parameter int NPORTS  = 5,
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 3,
   parameter bit LATERAL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPORTS-1:0] req_i,
   input logic [NPORTS-1:0] gnt_o,
   input logic [SEL_W-1:0]  xbar_sel_o,
   input logic              src_empty_i,
   input logic              dn_req_o,
   input logic              dn_ack_i,
   input logic [DATA_W-1:0] dn_data_o
);

   p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   p_grant_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && $past(gnt_o) == '0) |-> (($past(req_i) & gnt_o) != '0));

   p_grant_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && !src_empty_i) |=> $stable(gnt_o));

   p_sel_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o == '0) |-> (xbar_sel_o == '0));

   p_sel_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0) |-> gnt_o[xbar_sel_o]);

   p_copy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && src_empty_i) |=> (gnt_o == '0));

   p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req_o && !dn_ack_i) |=> (dn_req_o && $stable(dn_data_o)));

   p_no_grant_in_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_o |-> (gnt_o == '0));

   generate
      if (LATERAL) begin : g_lat_chk
         p_no_vertical_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[PORT_NORTH] == 1'b0) && (gnt_o[PORT_SOUTH] == 1'b0));
      end
   endgenerate

endmodule

bind rr_out_chan rr_out_chan_chk #(
   .NPORTS(NPORTS), .DATA_W(DATA_W), .SEL_W(SEL_W), .LATERAL(LATERAL)
) i_rr_out_chan_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .gnt_o       (gnt_o),
   .xbar_sel_o  (xbar_sel_o),
   .src_empty_i (src_empty_i),
   .dn_req_o    (dn_req_o),
   .dn_ack_i    (dn_ack_i),
   .dn_data_o   (dn_data_o)
);

// File: tb/test_rr_out_chan.sv
`timescale 1ns/1ps
module test_rr_out_chan;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] req_i = '0;
   logic [4:0] gnt_o;
   logic [2:0] xbar_sel_o;
   logic [7:0] xbar_data_i = '0;
   logic       src_empty_i = 1'b1;
   logic       dn_req_o;
   logic       dn_ack_i = 1'b0;
   logic [7:0] dn_data_o;

   logic [4:0] l_req = '0;
   logic [4:0] l_gnt;
   logic [2:0] l_sel;
   logic       l_dreq;
   logic [7:0] l_ddata;

   always #2.5 clk = ~clk;

   rr_out_chan i_rr_out_chan (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o),
      .xbar_sel_o(xbar_sel_o), .xbar_data_i(xbar_data_i),
      .src_empty_i(src_empty_i), .dn_req_o(dn_req_o),
      .dn_ack_i(dn_ack_i), .dn_data_o(dn_data_o)
   );

   rr_out_chan #(.LATERAL(1'b1)) i_rr_out_chan_ew (
      .clk(clk), .rst_n(rst_n), .req_i(l_req), .gnt_o(l_gnt),
      .xbar_sel_o(l_sel), .xbar_data_i(8'h00),
      .src_empty_i(1'b1), .dn_req_o(l_dreq),
      .dn_ack_i(1'b0), .dn_data_o(l_ddata)
   );

   int nchk = 0, nerr = 0;
   int hi_m = 0, act = -1, act_len = 0, act_idx = 0, act_ser = 0;
   bit drove_empty = 0, prev_stall = 0, expect_drop = 0;
   logic [7:0] prev_data = '0;
   bit pend [5];
   int pend_len [5];
   int pend_ser [5];
   logic [7:0] exp_q [$];
   int order [$];
   int gen_pct = 0, ack_pct = 100, ser_ctr = 1, deliv = 0, dreq_seen = 0;
   logic [4:0] gen_mask = 5'b11111;

   function automatic logic [7:0] flit(int ser, int k);
      return 8'((ser * 37) + (k * 11) + 5);
   endfunction

   function automatic int pick(logic [4:0] r, int start);
      for (int i = 0; i < 5; i++) begin
         if (r[(start + i) % 5]) return (start + i) % 5;
      end
      return -1;
   endfunction

   task automatic check(bit ok, string tag, string what, int actual, int expected);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   task automatic add_pkt(int p, int len);
      pend[p] = 1; pend_len[p] = len; pend_ser[p] = ser_ctr; ser_ctr++;
      req_i[p] = 1'b1;
   endtask

   task automatic step();
      bit ack;
      int e;
      @(negedge clk);
      if (expect_drop) begin
         check(dn_req_o == 1'b0, "R6", "request after last flit", dn_req_o, 0);
         expect_drop = 0;
      end
      if (dn_req_o) dreq_seen++;
      if (prev_stall)
         check(dn_req_o && dn_data_o == prev_data, "R7", "held flit",
               dn_data_o, prev_data);
      ack = (($urandom % 100) < ack_pct);
      if (dn_req_o && ack) begin
         if (exp_q.size() == 0) check(0, "R6", "unexpected flit", dn_data_o, -1);
         else begin
            check(dn_data_o == exp_q[0], "R6", "flit value", dn_data_o, exp_q[0]);
            void'(exp_q.pop_front());
            deliv++;
            if (exp_q.size() == 0) expect_drop = 1;
         end
      end
      prev_stall = dn_req_o && !ack;
      prev_data  = dn_data_o;
      dn_ack_i   = ack;

      if (act >= 0) begin
         if (drove_empty) begin
            check(gnt_o == 5'b0 && xbar_sel_o == 3'd0, "R5", "grant after copy end",
                  gnt_o, 0);
            act = -1; drove_empty = 0;
         end else begin
            check(gnt_o == 5'(1 << act), "R2", "grant held during copy", gnt_o, 1 << act);
         end
      end else if (gnt_o != 5'b0) begin
         e = pick(req_i, hi_m);
         check(e >= 0 && gnt_o == 5'(1 << e), "R4", "round-robin winner", gnt_o,
               (e >= 0) ? (1 << e) : 0);
         check(e >= 0 && xbar_sel_o == 3'(e), "R3", "select index", xbar_sel_o, e);
         check(exp_q.size() == 0 && !dn_req_o, "R8", "grant while packet stored",
               exp_q.size(), 0);
         if (e < 0) begin
            e = 0;
            for (int i = 4; i >= 0; i--) if (gnt_o[i]) e = i;
         end
         act = e; order.push_back(e); hi_m = (e + 1) % 5;
         act_len = pend_len[e]; act_ser = pend_ser[e]; act_idx = 0;
         pend[e] = 0; req_i[e] = 1'b0;
         for (int k = 0; k < act_len; k++) exp_q.push_back(flit(act_ser, k));
      end
      if (act >= 0 && !drove_empty) begin
         if (act_idx < act_len) begin
            xbar_data_i = flit(act_ser, act_idx); src_empty_i = 1'b0; act_idx++;
         end else begin
            src_empty_i = 1'b1; drove_empty = 1;
         end
      end
      for (int p = 0; p < 5; p++) begin
         if (!pend[p] && p != act && gen_mask[p] && (($urandom % 100) < gen_pct))
            add_pkt(p, int'($urandom % 17));
      end
   endtask

   function automatic bit busy();
      bit any;
      any = 0;
      for (int p = 0; p < 5; p++) any |= pend[p];
      return any || act >= 0 || exp_q.size() != 0 || dn_req_o;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0c11));
      for (int p = 0; p < 5; p++) pend[p] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(gnt_o == 5'b0, "R1", "grant in reset", gnt_o, 0);
      check(xbar_sel_o == 3'd0, "R1", "select in reset", xbar_sel_o, 0);
      check(dn_req_o == 1'b0, "R1", "request in reset", dn_req_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gnt_o == 5'b0 && dn_req_o == 1'b0, "R1", "first cycle after reset", gnt_o, 0);

      // all five request together from reset
      for (int p = 0; p < 5; p++) add_pkt(p, 2);
      ack_pct = 100; gen_pct = 0;
      for (int n = 0; n < 400 && busy(); n++) step();
      check(order.size() == 5, "R4", "grants in first round", order.size(), 5);
      for (int i = 0; i < 5 && i < order.size(); i++)
         check(order[i] == i, "R4", "rotation order", order[i], i);

      // empty packet
      add_pkt(2, 0);
      dreq_seen = 0;
      for (int n = 0; n < 12; n++) step();
      check(order[order.size() - 1] == 2, "R5", "empty packet granted", order[order.size() - 1], 2);
      check(dreq_seen == 0, "R5", "empty packet send cycles", dreq_seen, 0);

      // full packet
      deliv = 0;
      add_pkt(4, 16);
      for (int n = 0; n < 200 && busy(); n++) step();
      check(deliv == 16, "R10", "flits of full packet", deliv, 16);

      // random traffic with stalls
      gen_pct = 20; ack_pct = 60;
      for (int n = 0; n < 3000; n++) step();
      gen_pct = 0; ack_pct = 100;
      for (int n = 0; n < 3000 && busy(); n++) step();
      check(exp_q.size() == 0, "R6", "flits left undelivered", exp_q.size(), 0);
      check(dn_req_o == 1'b0, "R6", "request after drain", dn_req_o, 0);

      // horizontal variant: vertical requests alone are ignored
      begin
         bit seen;
         seen = 0;
         @(negedge clk);
         l_req = 5'b11000;
         for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            if (l_gnt != 5'b0 || l_dreq) seen = 1;
         end
         check(!seen, "R9", "grant for vertical-only requests", seen, 0);
         l_req = 5'b11010;
         @(negedge clk);
         check(l_gnt == 5'b00010 && l_sel == 3'd1, "R9", "east wins over vertical", l_gnt, 2);
         l_req = 5'b11000;
         repeat (4) @(negedge clk);
         l_req = 5'b11001;
         @(negedge clk);
         check(l_gnt == 5'b00001 && l_sel == 3'd0, "R9", "search skips vertical to local",
               l_gnt, 1);
         l_req = 5'b00000;
         repeat (4) @(negedge clk);
      end

      summary();
      $finish;
   end

endmodule